// File: doc/BRIEF.md
# Explicit-Parallel Bundle Issue Unit

This block sits between an instruction fetch buffer and the execution units of a statically scheduled core. It takes 128-bit bundles, each holding a 5-bit template and three 41-bit operation slots. From the template it learns the unit class of every slot and where the compiler placed stop markers. It then issues one issue group per cycle on six issue lanes. Each lane carries a unit tag and the opaque 41-bit operation.

An issue group runs in slot order from the current slot up to and including the first stop. If the older held bundle has no stop, the group carries on into the next bundle. It closes at a stop, or at the last slot of the second held bundle. No dependence or structural check is made inside a group. A busy unit holds back the whole group that needs it, and every group behind it. The input takes up to two bundles per cycle through a valid/ready handshake. Up to two bundles retire per cycle, so a group that spans two bundles frees both at once.

Top module: `bundle_issue_unit`

## Requirements
- R1: A bundle holds its template in bits [4:0] and slot j in bits [5+41j +: 41]. An issued lane k carries the payload of window position k on iss_op[41k +: 41]. Position k is bundle k/3 of the window (0 is the older one) and slot k%3 of that bundle.
- R2: The template's bit 0 marks a stop after slot 2, and bits [4:1] pick a type pattern with optional mid stops. In slot order, the patterns are: 0 M,I,I; 1 M,I,I with a stop after slot 1; 2 M,M,I; 3 M,M,I with a stop after slot 0; 4 M,F,I; 5 M,M,F; 6 M,I,B; 7 M,B,B; 8 B,B,B; 9 M,M,B; 10 M,F,B; 11 M,I,I with a stop after slot 0. iss_unit[2k +: 2] gives the lane's unit as M=0, I=1, F=2, B=3.
- R3: A pattern code of 12 to 15 is undefined. If such a bundle is accepted on input lane n, bad_template[n] is high in that cycle, the bundle is dropped, and none of its slots is ever issued.
- R4: The issued group covers the window positions from the current slot up to and including the first stop. iss_valid is high exactly on those lanes.
- R5: If the older bundle has no stop at or after the current slot, the group continues into the second bundle. When that bundle also has no stop, the group closes at its last slot.
- R6: If no stop is reached and only one bundle is held, nothing issues and the held bundle waits.
- R7: If any operation of the group targets a unit whose unit_busy bit (indexed by the unit code) is high, no lane issues. The same group is offered again in the next cycle.
- R8: A group ending in the last slot of the second bundle retires both bundles in one cycle. in_ready is high exactly when at least two of the four window entries are free after this cycle's retirement. in_valid bits are accepted only while in_ready is high, with lane a placed ahead of lane b.
- R9: After reset the window is empty, in_ready is high and no lane issues.
- R10: Groups issue in slot order, and every slot of every accepted legal bundle issues exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 2 | Bundle offered on lane a (bit 0) and lane b (bit 1) |
| in_bundle_a | input | 128 | Older of the two offered bundles |
| in_bundle_b | input | 128 | Younger of the two offered bundles |
| in_ready | output | 1 | Both lanes may be accepted in this cycle |
| bad_template | output | 2 | Accepted bundle on that lane had an undefined template |
| unit_busy | input | 4 | Per-unit hold, indexed by unit code |
| iss_valid | output | 6 | Lane issues in this cycle |
| iss_unit | output | 12 | Unit code per lane, 2 bits each |
| iss_op | output | 246 | Operation payload per lane, 41 bits each |

## Verification
The hardest state to reach is a group that must span two bundles while the window is also full and under backpressure. This needs bundles without closing stops to arrive in pairs while units are busy. Directed sequences build this state on purpose: a stop-free bundle left waiting alone, then paired stop-free bundles forcing a closure at the window end, then an all-busy phase that fills the window until in_ready drops. Random stimulus follows with a fixed seed. It mixes undefined templates, paired and single offers and bursts of busy units, and a bench model predicts every lane, unit tag, payload and ready value in every cycle.

// File: rtl/bundle_issue_pkg.sv
// Shared constants, unit codes and template decode for the bundle issue unit.
// Assumes the fixed 128-bit bundle layout: 5-bit template low, three 41-bit slots above.
package bundle_issue_pkg;
    localparam int SLOT_W    = 41;
    localparam int TMPL_W    = 5;
    localparam int SLOTS     = 3;
    localparam int BUNDLE_W  = TMPL_W + SLOTS * SLOT_W;
    localparam int WIN_B     = 2;
    localparam int LANES     = WIN_B * SLOTS;
    localparam int NUM_UNITS = 4;
    localparam int UNIT_W    = 2;

    typedef enum logic [1:0] {
        UNIT_MEM = 2'd0,
        UNIT_INT = 2'd1,
        UNIT_FP  = 2'd2,
        UNIT_BR  = 2'd3
    } unit_e;

    typedef struct packed {
        logic                        legal;
        logic [SLOTS-1:0]            stop;
        logic [SLOTS*UNIT_W-1:0]     units;
    } tmpl_info_t;

    // Decode a template: pattern code in [4:1], closing stop in [0].
    function automatic tmpl_info_t decode_tmpl(input logic [TMPL_W-1:0] t);
        tmpl_info_t r;
        r.legal = 1'b1;
        r.stop  = {t[0], 2'b00};
        case (t[4:1])
            4'd0:  r.units = {UNIT_INT, UNIT_INT, UNIT_MEM};
            4'd1:  begin r.units = {UNIT_INT, UNIT_INT, UNIT_MEM}; r.stop[1] = 1'b1; end
            4'd2:  r.units = {UNIT_INT, UNIT_MEM, UNIT_MEM};
            4'd3:  begin r.units = {UNIT_INT, UNIT_MEM, UNIT_MEM}; r.stop[0] = 1'b1; end
            4'd4:  r.units = {UNIT_INT, UNIT_FP,  UNIT_MEM};
            4'd5:  r.units = {UNIT_FP,  UNIT_MEM, UNIT_MEM};
            4'd6:  r.units = {UNIT_BR,  UNIT_INT, UNIT_MEM};
            4'd7:  r.units = {UNIT_BR,  UNIT_BR,  UNIT_MEM};
            4'd8:  r.units = {UNIT_BR,  UNIT_BR,  UNIT_BR};
            4'd9:  r.units = {UNIT_BR,  UNIT_MEM, UNIT_MEM};
            4'd10: r.units = {UNIT_BR,  UNIT_FP,  UNIT_MEM};
            4'd11: begin r.units = {UNIT_INT, UNIT_INT, UNIT_MEM}; r.stop[0] = 1'b1; end
            default: begin r.units = '0; r.stop = '0; r.legal = 1'b0; end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/bundle_tmpl_decode.sv
// Template decoder for one bundle: legality, per-slot stop flags, per-slot unit codes.
// Purely combinational; assumes the template occupies the low TMPL_W bits.
module bundle_tmpl_decode
    import bundle_issue_pkg::*;
(
    input  logic [BUNDLE_W-1:0]      bundle,
    output logic                     legal,
    output logic [SLOTS-1:0]         stop,
    output logic [SLOTS*UNIT_W-1:0]  units
);
    tmpl_info_t info;

    // Split the decoded template into its fields.
    always_comb begin
        info  = decode_tmpl(bundle[TMPL_W-1:0]);
        legal = info.legal;
        stop  = info.stop;
        units = info.units;
    end
endmodule

// File: rtl/bundle_window.sv
// Shift-style bundle window of DEPTH entries, oldest at index 0.
// Retires up to two entries and appends up to two per cycle; assumes the
// caller never pushes beyond free space and never pops more than held.
module bundle_window
    import bundle_issue_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             pop_cnt,
    input  logic [1:0]             push_cnt,
    input  logic [BUNDLE_W-1:0]    push_d0,
    input  logic [BUNDLE_W-1:0]    push_d1,
    output logic [BUNDLE_W-1:0]    head0,
    output logic [BUNDLE_W-1:0]    head1,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int CW = $clog2(DEPTH+1);

    logic [BUNDLE_W-1:0] mem     [DEPTH];
    logic [BUNDLE_W-1:0] mem_nxt [DEPTH];
    logic [CW-1:0]       cnt_nxt;

    // Next window contents: shift out retired entries, then append new ones.
    always_comb begin
        int remain;
        remain = int'(count) - int'(pop_cnt);
        for (int i = 0; i < DEPTH; i++) begin
            mem_nxt[i] = (i + int'(pop_cnt) < DEPTH) ? mem[i + int'(pop_cnt)] : '0;
        end
        if (push_cnt != 2'd0 && remain < DEPTH) begin
            mem_nxt[remain] = push_d0;
        end
        if (push_cnt == 2'd2 && remain + 1 < DEPTH) begin
            mem_nxt[remain + 1] = push_d1;
        end
        cnt_nxt = CW'(remain + int'(push_cnt));
    end

    // Register the window state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            count <= cnt_nxt;
            for (int i = 0; i < DEPTH; i++) mem[i] <= mem_nxt[i];
        end
    end

    assign head0 = mem[0];
    assign head1 = mem[1];
endmodule

// File: rtl/issue_group_former.sv
// Forms the issue group over the two oldest bundles starting at the slot pointer:
// up to the first stop, or the last slot of the second bundle. Holds the group when
// a needed unit is busy and works out how many bundles retire and the new pointer.
module issue_group_former
    import bundle_issue_pkg::*;
(
    input  logic [WIN_B-1:0]          have,
    input  logic [LANES-1:0]          stop_lin,
    input  logic [LANES*UNIT_W-1:0]   unit_lin,
    input  logic [1:0]                ptr,
    input  logic [NUM_UNITS-1:0]      busy,
    output logic [LANES-1:0]          grp_mask,
    output logic                      fire,
    output logic [1:0]                pop,
    output logic [1:0]                ptr_nxt
);
    logic found;
    logic blocked;
    int   last;

    // Locate the closing slot of the group.
    always_comb begin
        found = 1'b0;
        last  = 0;
        for (int k = 0; k < LANES; k++) begin
            if (!found && k >= int'(ptr) && have[k / SLOTS] &&
                (stop_lin[k] || k == LANES - 1)) begin
                found = 1'b1;
                last  = k;
            end
        end
    end

    // Build the lane mask and test it against busy units.
    always_comb begin
        blocked = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            grp_mask[k] = found && k >= int'(ptr) && k <= last;
            if (grp_mask[k] && busy[unit_lin[k*UNIT_W +: UNIT_W]]) blocked = 1'b1;
        end
        fire = found && !blocked;
    end

    // Retirement count and next slot pointer.
    always_comb begin
        pop     = 2'd0;
        ptr_nxt = ptr;
        if (fire) begin
            if (last < SLOTS - 1) begin
                ptr_nxt = 2'(last + 1);
            end else if (last == SLOTS - 1) begin
                pop     = 2'd1;
                ptr_nxt = 2'd0;
            end else if (last < LANES - 1) begin
                pop     = 2'd1;
                ptr_nxt = 2'(last - SLOTS + 1);
            end else begin
                pop     = 2'd2;
                ptr_nxt = 2'd0;
            end
        end
    end
endmodule

// File: rtl/bundle_issue_unit.sv
// Top of the bundle issue unit. Accepts up to two bundles per cycle, drops
// bundles with undefined templates, keeps a DEPTH-entry window and issues one
// stop-bounded group per cycle on LANES lanes. Assumes DEPTH >= 4 so that two
// held bundles plus two arrivals always fit.
module bundle_issue_unit
    import bundle_issue_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  in_valid,
    input  logic [BUNDLE_W-1:0]         in_bundle_a,
    input  logic [BUNDLE_W-1:0]         in_bundle_b,
    output logic                        in_ready,
    output logic [1:0]                  bad_template,
    input  logic [NUM_UNITS-1:0]        unit_busy,
    output logic [LANES-1:0]            iss_valid,
    output logic [LANES*UNIT_W-1:0]     iss_unit,
    output logic [LANES*SLOT_W-1:0]     iss_op
);
    localparam int CW = $clog2(DEPTH+1);

    logic [BUNDLE_W-1:0]       in_bnd   [2];
    logic [1:0]                in_legal;
    logic [SLOTS-1:0]          in_stop  [2];
    logic [SLOTS*UNIT_W-1:0]   in_units [2];
    logic [1:0]                accept;
    logic [1:0]                push_ok;
    logic [1:0]                push_cnt;
    logic [BUNDLE_W-1:0]       push_d0;
    logic [BUNDLE_W-1:0]       push_d1;

    logic [BUNDLE_W-1:0]       head     [WIN_B];
    logic [WIN_B-1:0]          head_legal;
    logic [SLOTS-1:0]          head_stop  [WIN_B];
    logic [SLOTS*UNIT_W-1:0]   head_units [WIN_B];
    logic [CW-1:0]             win_cnt;
    logic [WIN_B-1:0]          have;
    logic [LANES-1:0]          stop_lin;
    logic [LANES*UNIT_W-1:0]   unit_lin;
    logic [LANES-1:0]          grp_mask;
    logic                      fire;
    logic [1:0]                pop;
    logic [1:0]                ptr;
    logic [1:0]                ptr_nxt;

    assign in_bnd[0] = in_bundle_a;
    assign in_bnd[1] = in_bundle_b;

    // Input-side decoders, one per offered lane.
    for (genvar n = 0; n < 2; n++) begin : g_in_dec
        bundle_tmpl_decode u_dec (
            .bundle (in_bnd[n]),
            .legal  (in_legal[n]),
            .stop   (in_stop[n]),
            .units  (in_units[n])
        );
    end

    // Handshake, illegal-template flagging and push compaction.
    always_comb begin
        in_ready     = (DEPTH - int'(win_cnt) + int'(pop)) >= 2;
        accept       = in_valid & {2{in_ready}};
        push_ok      = accept & in_legal;
        bad_template = accept & ~in_legal;
        push_cnt     = 2'(int'(push_ok[0]) + int'(push_ok[1]));
        push_d0      = push_ok[0] ? in_bundle_a : in_bundle_b;
        push_d1      = in_bundle_b;
    end

    bundle_window #(.DEPTH(DEPTH)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop_cnt  (pop),
        .push_cnt (push_cnt),
        .push_d0  (push_d0),
        .push_d1  (push_d1),
        .head0    (head[0]),
        .head1    (head[1]),
        .count    (win_cnt)
    );

    // Window-side decoders for the two oldest bundles, flattened into lanes.
    for (genvar b = 0; b < WIN_B; b++) begin : g_win_dec
        bundle_tmpl_decode u_dec (
            .bundle (head[b]),
            .legal  (head_legal[b]),
            .stop   (head_stop[b]),
            .units  (head_units[b])
        );
        assign have[b] = (int'(win_cnt) > b) && head_legal[b];
        assign stop_lin[b*SLOTS +: SLOTS]               = head_stop[b];
        assign unit_lin[b*SLOTS*UNIT_W +: SLOTS*UNIT_W] = head_units[b];
        for (genvar j = 0; j < SLOTS; j++) begin : g_slot
            assign iss_op[(b*SLOTS+j)*SLOT_W +: SLOT_W] =
                head[b][TMPL_W + j*SLOT_W +: SLOT_W];
        end
    end

    issue_group_former u_grp (
        .have     (have),
        .stop_lin (stop_lin),
        .unit_lin (unit_lin),
        .ptr      (ptr),
        .busy     (unit_busy),
        .grp_mask (grp_mask),
        .fire     (fire),
        .pop      (pop),
        .ptr_nxt  (ptr_nxt)
    );

    assign iss_valid = grp_mask & {LANES{fire}};
    assign iss_unit  = unit_lin;

    // Slot pointer within the oldest bundle.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= 2'd0;
        else        ptr <= ptr_nxt;
    end
endmodule

// File: rtl/bundle_issue_checker.sv
// Assertion checker for the bundle issue unit, attached by bind below.
module bundle_issue_checker
    import bundle_issue_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [1:0]                in_valid,
    input logic                      in_ready,
    input logic [1:0]                bad_template,
    input logic [NUM_UNITS-1:0]      unit_busy,
    input logic [LANES-1:0]          iss_valid,
    input logic [LANES*UNIT_W-1:0]   iss_unit,
    input logic [$clog2(DEPTH+1)-1:0] win_cnt
);
    logic [LANES:0] run_edges;
    logic           busy_hit;

    // Edge count of the issue mask and busy-unit collision detect.
    always_comb begin
        run_edges = {1'b0, iss_valid} ^ {iss_valid, 1'b0};
        busy_hit  = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            if (iss_valid[k] && unit_busy[iss_unit[k*UNIT_W +: UNIT_W]]) busy_hit = 1'b1;
        end
    end

    AST_GROUP_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(run_edges) <= 2); // R4
    AST_NO_BUSY_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_hit); // R7
    AST_BAD_ONLY_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_template & ~(in_valid & {2{in_ready}})) == 2'b00); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(win_cnt) <= DEPTH); // R8
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (in_ready && iss_valid == '0)); // R9
    AST_NEED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (win_cnt == '0) |-> (iss_valid == '0)); // R10
endmodule

bind bundle_issue_unit bundle_issue_checker #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .bad_template (bad_template),
    .unit_busy    (unit_busy),
    .iss_valid    (iss_valid),
    .iss_unit     (iss_unit),
    .win_cnt      (win_cnt)
);

// File: tb/bundle_issue_unit_test.sv
`timescale 1ns/1ps
module bundle_issue_unit_test;
    localparam int DEPTH = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   in_valid = '0;
    logic [127:0] in_bundle_a = '0;
    logic [127:0] in_bundle_b = '0;
    logic         in_ready;
    logic [1:0]   bad_template;
    logic [3:0]   unit_busy = '0;
    logic [5:0]   iss_valid;
    logic [11:0]  iss_unit;
    logic [245:0] iss_op;

    int checks = 0;
    int fails  = 0;
    logic [127:0] mq [0:7];
    int mcnt = 0;
    int mptr = 0;

    bundle_issue_unit #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_bundle_a(in_bundle_a), .in_bundle_b(in_bundle_b),
        .in_ready(in_ready), .bad_template(bad_template),
        .unit_busy(unit_busy), .iss_valid(iss_valid),
        .iss_unit(iss_unit), .iss_op(iss_op)
    );

    always #2.5 clk = ~clk;

    // Pattern table of R2: unit codes M=0 I=1 F=2 B=3 per slot.
    function automatic logic tb_legal(input logic [4:0] t);
        return t[4:1] < 4'd12;
    endfunction

    function automatic logic [1:0] tb_unit(input logic [4:0] t, input int j);
        logic [1:0] u [3];
        case (t[4:1])
            0, 1, 11: u = '{2'd0, 2'd1, 2'd1};
            2, 3:     u = '{2'd0, 2'd0, 2'd1};
            4:        u = '{2'd0, 2'd2, 2'd1};
            5:        u = '{2'd0, 2'd0, 2'd2};
            6:        u = '{2'd0, 2'd1, 2'd3};
            7:        u = '{2'd0, 2'd3, 2'd3};
            8:        u = '{2'd3, 2'd3, 2'd3};
            9:        u = '{2'd0, 2'd0, 2'd3};
            10:       u = '{2'd0, 2'd2, 2'd3};
            default:  u = '{2'd0, 2'd0, 2'd0};
        endcase
        return u[j];
    endfunction

    function automatic logic tb_stop(input logic [4:0] t, input int j);
        if (j == 2) return t[0];
        if (j == 1) return t[4:1] == 4'd1;
        return t[4:1] == 4'd3 || t[4:1] == 4'd11;
    endfunction

    function automatic logic [127:0] mk(input logic [4:0] t);
        logic [127:0] v;
        v = {$urandom(), $urandom(), $urandom(), $urandom()};
        v[4:0] = t;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One cycle: drive, predict from the model, compare, then advance the model.
    task automatic step(input logic [1:0] v, input logic [127:0] a, input logic [127:0] b,
                        input logic [3:0] busy, input string tag);
        logic [5:0] emask;
        logic found, blocked, eready;
        int last, pop, nptr;
        @(negedge clk);
        in_valid = v; in_bundle_a = a; in_bundle_b = b; unit_busy = busy;
        #1;
        found = 0; last = 0;
        for (int k = 0; k < 6; k++) begin
            if (!found && k >= mptr && mcnt > k / 3 &&
                (tb_stop(mq[k/3][4:0], k % 3) || k == 5)) begin
                found = 1; last = k;
            end
        end
        blocked = 0;
        for (int k = 0; k < 6; k++) begin
            emask[k] = found && k >= mptr && k <= last;
            if (emask[k] && busy[tb_unit(mq[k/3][4:0], k % 3)]) blocked = 1;
        end
        if (blocked) emask = '0;
        pop = 0; nptr = mptr;
        if (emask != 0) begin
            if (last < 2)      nptr = last + 1;
            else if (last == 2) begin pop = 1; nptr = 0; end
            else if (last < 5) begin pop = 1; nptr = last - 2; end
            else               begin pop = 2; nptr = 0; end
        end
        eready = (DEPTH - (mcnt - pop)) >= 2;
        chk({tag, " issue mask"}, 256'(iss_valid), 256'(emask));
        chk("R8 in_ready", 256'(in_ready), 256'(eready));
        chk("R3 bad_template", 256'(bad_template),
            256'({v[1] && eready && !tb_legal(b[4:0]), v[0] && eready && !tb_legal(a[4:0])}));
        for (int k = 0; k < 6; k++) begin
            if (emask[k]) begin
                chk("R1 lane payload", 256'(iss_op[k*41 +: 41]),
                    256'(mq[k/3][5 + 41*(k%3) +: 41]));
                chk("R2 lane unit", 256'(iss_unit[k*2 +: 2]),
                    256'(tb_unit(mq[k/3][4:0], k % 3)));
            end
        end
        for (int i = 0; i < 6; i++) mq[i] = mq[i + pop];
        mcnt -= pop; mptr = nptr;
        if (eready && v[0] && tb_legal(a[4:0])) begin mq[mcnt] = a; mcnt++; end
        if (eready && v[1] && tb_legal(b[4:0])) begin mq[mcnt] = b; mcnt++; end
    endtask

    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL R10 watchdog: run did not complete");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [127:0] keep;
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        #1;
        chk("R9 ready in reset window", 256'(in_ready), 256'(1));
        @(negedge clk); rst_n = 1'b1;
        step(2'b00, '0, '0, 4'h0, "R9");
        chk("R9 no issue after reset", 256'(iss_valid), 256'(0));

        // R6: a lone bundle with no stop waits.
        step(2'b01, mk(5'd0), '0, 4'h0, "R6");
        step(2'b00, '0, '0, 4'h0, "R6");
        chk("R6 lone stop-free bundle waits", 256'(iss_valid), 256'(0));
        // R5: the group runs into the second bundle.
        step(2'b01, mk(5'd1), '0, 4'h0, "R5");
        step(2'b00, '0, '0, 4'h0, "R5");
        chk("R5 group spans two bundles", 256'(iss_valid), 256'(6'h3F));
        // R4 and R10: mid stop then end stop, in slot order.
        step(2'b01, mk(5'd3), '0, 4'h0, "R4");
        step(2'b00, '0, '0, 4'h0, "R4");
        chk("R4 group ends at mid stop", 256'(iss_valid), 256'(6'h03));
        step(2'b00, '0, '0, 4'h0, "R10");
        chk("R10 remaining slot issues next", 256'(iss_valid), 256'(6'h04));
        // R7: a busy branch unit holds an all-branch group.
        step(2'b01, mk(5'd17), '0, 4'h0, "R7");
        step(2'b00, '0, '0, 4'h8, "R7");
        chk("R7 busy unit holds group", 256'(iss_valid), 256'(0));
        step(2'b00, '0, '0, 4'h1, "R7");
        chk("R7 unrelated busy unit does not hold", 256'(iss_valid), 256'(6'h07));
        // R3: undefined template on lane a is dropped.
        keep = mk(5'd17);
        step(2'b11, mk(5'd24), keep, 4'h0, "R3");
        chk("R3 flag on lane a only", 256'(bad_template), 256'(2'b01));
        step(2'b00, '0, '0, 4'h0, "R3");
        chk("R3 dropped bundle not issued", 256'(iss_op[40:0]), 256'(keep[45:5]));
        // R5 and R8: two stop-free bundles close at window end, both retire.
        step(2'b11, mk(5'd0), mk(5'd0), 4'h0, "R5");
        step(2'b00, '0, '0, 4'h0, "R5");
        chk("R5 forced close at window end", 256'(iss_valid), 256'(6'h3F));
        // R8: fill the window under a full stall.
        step(2'b11, mk(5'd17), mk(5'd17), 4'hF, "R8");
        step(2'b11, mk(5'd17), mk(5'd17), 4'hF, "R8");
        step(2'b11, mk(5'd17), mk(5'd17), 4'hF, "R8");
        chk("R8 backpressure when full", 256'(in_ready), 256'(0));
        step(2'b00, '0, '0, 4'h0, "R8");

        // Constrained random phase.
        for (int n = 0; n < 4000; n++) begin
            logic [1:0] v;
            logic [3:0] bz;
            v  = 2'($urandom_range(0, 3));
            bz = ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'h0;
            step(v, mk(5'($urandom())), mk(5'($urandom())), bz, "R4");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule